// File: doc/BRIEF.md
# Associative Page Translation Cache

This block is a small, fully associative store of recent virtual-to-physical page translations for a processor with an 18-bit word address. The upper nine address bits name a virtual page and the lower nine bits are the word offset inside it. Every request carries a mode flag, user or executive, because the two modes walk separate page tables. A stored translation matches only a request of its own mode and its own virtual page. On a match the block combinationally returns the physical page joined with the untouched offset.

When no entry matches, the block raises a miss. The requester keeps its request steady while an external table walker fetches the translation and delivers it on the refill strobe. The retried access then hits. New translations overwrite entries in a fixed rotation driven by one victim pointer. A refill whose mode and page are already present rewrites that entry in place, so a tag never appears twice. Each entry holds a write-permission bit. A store that reaches a read-only page gives a protection fault rather than a hit. Two flush inputs invalidate either every entry or only the entries of one mode.

Top module: `xlat_cache`

## Requirements
- R1: The request address splits into a page number (bits 17:9) and a word offset (bits 8:0). On a hit, `phys_addr` equals the stored physical page in bits 21:9 joined with the request offset in bits 8:0.
- R2: An entry hits only when its mode bit equals `req_user` (1 = user, 0 = executive) and its page equals the request page. The two modes can hold the same page number with different physical pages.
- R3: While `req_valid` is high, exactly one of `hit`, `miss` and `prot_fault` is high in the same cycle, with no register on the path. While `req_valid` is low, all three are low. A request that matches no valid entry gives `miss`.
- R4: A refill strobe writes mode, page, physical page and write permission at the clock edge. The same request issued in the next cycle hits.
- R5: Refills of new tags fill entries in rotating order and wrap after the last entry. With N entries, the (N+1)-th new tag after a full flush evicts the first one, and the rest stay present.
- R6: `flush_all` invalidates every entry in one cycle and returns the victim pointer to entry 0.
- R7: `flush_mode_valid` invalidates only the entries whose mode bit equals `flush_mode_user`. Entries of the other mode keep hitting.
- R8: A refill whose mode and page match a valid entry overwrites that entry and leaves the victim pointer unchanged. No two valid entries ever share a tag.
- R9: A request with `req_write` = 1 that matches an entry whose write-permission bit is 0 raises `prot_fault` and not `hit`. A read of the same entry hits. A write to a writable entry hits.
- R10: After reset every entry is invalid and any request misses.
- R11: A refill in the same cycle as either flush input is dropped. The flush alone takes effect.
- R12: The block behaves the same with `NUM_ENTRIES` = 1: each new refill replaces the only entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 18 | Virtual word address |
| req_user | input | 1 | Request mode, 1 = user, 0 = executive |
| req_write | input | 1 | Request is a store |
| hit | output | 1 | Translation found and access permitted |
| miss | output | 1 | No matching entry |
| prot_fault | output | 1 | Store to a read-only page |
| phys_addr | output | 22 | Physical page and offset, valid with hit |
| refill_valid | input | 1 | Refill strobe from the walker |
| refill_user | input | 1 | Mode of the refilled translation |
| refill_vpn | input | 9 | Virtual page of the refill |
| refill_ppn | input | 13 | Physical page of the refill |
| refill_wr_ok | input | 1 | Write permission of the refill |
| flush_all | input | 1 | Invalidate every entry |
| flush_mode_valid | input | 1 | Invalidate entries of one mode |
| flush_mode_user | input | 1 | Mode chosen by the per-mode flush |

## Verification
Lookups are tried with the same page in both modes, which separates a correct mode tag from a tag that ignores mode. Reads and writes to the same page separate the permission check from the plain match. A run of N+1 distinct pages after a flush shows whether replacement rotates and wraps, or whether it picks a wrong victim. A repeated refill of one page, followed by N-1 fresh pages, shows whether a duplicate moves the pointer, because an early eviction appears as an unexpected miss. A second instance with one entry covers the smallest size.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W  = 18;
    localparam int VPN_W = 9;
    localparam int OFF_W = 9;
    localparam int PPN_W = 13;
    localparam int PA_W  = PPN_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic             user;
        logic             wr_ok;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } xlat_entry_t;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_HIT,
        LK_MISS,
        LK_FAULT
    } lookup_res_e;

    function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] a);
        return a[VA_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] a);
        return a[OFF_W-1:0];
    endfunction

    function automatic logic tag_eq(input xlat_entry_t e, input logic user,
                                    input logic [VPN_W-1:0] vpn);
        return e.valid && (e.user == user) && (e.vpn == vpn);
    endfunction

endpackage

// File: rtl/xlat_entry_bank.sv
module xlat_entry_bank
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush_all,
    input  logic        flush_mode_valid,
    input  logic        flush_mode_user,
    input  logic [NUM_ENTRIES-1:0] wr_en,
    input  xlat_entry_t wr_data,
    output xlat_entry_t ents [NUM_ENTRIES]
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i] <= '0;
            end else if (flush_all) begin
                ents[i].valid <= 1'b0;
            end else if (flush_mode_valid) begin
                if (ents[i].user == flush_mode_user) begin
                    ents[i].valid <= 1'b0;
                end
            end else if (wr_en[i]) begin
                ents[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  xlat_entry_t      ents [NUM_ENTRIES],
    input  logic             user,
    input  logic [VPN_W-1:0] vpn,
    output logic [NUM_ENTRIES-1:0] match,
    output logic             any
);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign match[i] = tag_eq(ents[i], user, vpn);
    end

    assign any = |match;

endmodule

// File: rtl/xlat_victim_ptr.sv
module xlat_victim_ptr #(
    parameter int NUM_ENTRIES = 16,
    parameter int PTR_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_hit_mux.sv
module xlat_hit_mux
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  xlat_entry_t ents [NUM_ENTRIES],
    input  logic [NUM_ENTRIES-1:0] match,
    input  logic        req_valid,
    input  logic        req_write,
    output lookup_res_e res,
    output logic [PPN_W-1:0] ppn
);

    logic wr_ok;

    always_comb begin
        ppn   = '0;
        wr_ok = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            ppn   = ppn | (ents[i].ppn & {PPN_W{match[i]}});
            wr_ok = wr_ok | (match[i] & ents[i].wr_ok);
        end
        if (!req_valid) begin
            res = LK_IDLE;
        end else if (match == '0) begin
            res = LK_MISS;
        end else if (req_write && !wr_ok) begin
            res = LK_FAULT;
        end else begin
            res = LK_HIT;
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_addr,
    input  logic                req_user,
    input  logic                req_write,
    output logic                hit,
    output logic                miss,
    output logic                prot_fault,
    output logic [PA_W-1:0]     phys_addr,
    input  logic                refill_valid,
    input  logic                refill_user,
    input  logic [VPN_W-1:0]    refill_vpn,
    input  logic [PPN_W-1:0]    refill_ppn,
    input  logic                refill_wr_ok,
    input  logic                flush_all,
    input  logic                flush_mode_valid,
    input  logic                flush_mode_user
);

    localparam int PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    xlat_entry_t            ents [NUM_ENTRIES];
    xlat_entry_t            wr_data;
    logic [NUM_ENTRIES-1:0] wr_en;
    logic [NUM_ENTRIES-1:0] look_vec;
    logic [NUM_ENTRIES-1:0] dup_vec;
    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [NUM_ENTRIES-1:0] user_vec;
    logic                   look_any;
    logic                   dup_any;
    logic                   refill_go;
    logic [PTR_W-1:0]       ptr;
    lookup_res_e            res;
    logic [PPN_W-1:0]       hit_ppn;

    assign refill_go = refill_valid && !flush_all && !flush_mode_valid;

    assign wr_data = '{valid: 1'b1, user: refill_user, wr_ok: refill_wr_ok,
                       vpn: refill_vpn, ppn: refill_ppn};

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_sel
        assign wr_en[i]     = refill_go && (dup_any ? dup_vec[i] : (ptr == PTR_W'(i)));
        assign valid_vec[i] = ents[i].valid;
        assign user_vec[i]  = ents[i].user;
    end

    xlat_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) u_bank (
        .clk              (clk),
        .rst              (rst),
        .flush_all        (flush_all),
        .flush_mode_valid (flush_mode_valid),
        .flush_mode_user  (flush_mode_user),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .ents             (ents)
    );

    xlat_tag_cmp #(.NUM_ENTRIES(NUM_ENTRIES)) u_look_cmp (
        .ents  (ents),
        .user  (req_user),
        .vpn   (page_of(req_addr)),
        .match (look_vec),
        .any   (look_any)
    );

    xlat_tag_cmp #(.NUM_ENTRIES(NUM_ENTRIES)) u_dup_cmp (
        .ents  (ents),
        .user  (refill_user),
        .vpn   (refill_vpn),
        .match (dup_vec),
        .any   (dup_any)
    );

    xlat_victim_ptr #(.NUM_ENTRIES(NUM_ENTRIES), .PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .clear   (flush_all),
        .advance (refill_go && !dup_any),
        .ptr     (ptr)
    );

    xlat_hit_mux #(.NUM_ENTRIES(NUM_ENTRIES)) u_mux (
        .ents      (ents),
        .match     (look_vec),
        .req_valid (req_valid),
        .req_write (req_write),
        .res       (res),
        .ppn       (hit_ppn)
    );

    assign hit        = (res == LK_HIT);
    assign miss       = (res == LK_MISS);
    assign prot_fault = (res == LK_FAULT);
    assign phys_addr  = hit ? {hit_ppn, offset_of(req_addr)} : '0;

    logic unused_any;
    assign unused_any = look_any;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int NUM_ENTRIES = 16,
    parameter int PTR_W       = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic [17:0]            req_addr,
    input logic                   req_write,
    input logic                   hit,
    input logic                   miss,
    input logic                   prot_fault,
    input logic [21:0]            phys_addr,
    input logic                   refill_valid,
    input logic                   flush_all,
    input logic                   flush_mode_valid,
    input logic                   flush_mode_user,
    input logic [NUM_ENTRIES-1:0] look_vec,
    input logic [NUM_ENTRIES-1:0] valid_vec,
    input logic [NUM_ENTRIES-1:0] user_vec,
    input logic                   dup_any,
    input logic [PTR_W-1:0]       ptr
);

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_ENTRIES - 1)) ? '0 : p + 1'b1;
    endfunction

    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones({hit, miss, prot_fault}) == 1));

    assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> ({hit, miss, prot_fault} == 3'b000));

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        hit |-> (phys_addr[8:0] == req_addr[8:0]));

    assert_fault_on_store_R9: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> req_write);

    assert_unique_tag_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_vec));

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && !flush_all && !flush_mode_valid && dup_any) |=> $stable(ptr));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && !flush_all && !flush_mode_valid && !dup_any)
            |=> (ptr == step($past(ptr))));

    assert_flush_clear_R6: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> ((valid_vec == '0) && (ptr == '0)));

    assert_mode_flush_R7: assert property (@(posedge clk) disable iff (rst)
        (flush_mode_valid && !flush_all)
            |=> ((valid_vec & ($past(flush_mode_user) ? user_vec : ~user_vec)) == '0));

    assert_reset_empty_R10: assert property (@(posedge clk)
        rst |=> (valid_vec == '0));

endmodule

bind xlat_cache xlat_cache_chk #(.NUM_ENTRIES(NUM_ENTRIES), .PTR_W(PTR_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_addr         (req_addr),
    .req_write        (req_write),
    .hit              (hit),
    .miss             (miss),
    .prot_fault       (prot_fault),
    .phys_addr        (phys_addr),
    .refill_valid     (refill_valid),
    .flush_all        (flush_all),
    .flush_mode_valid (flush_mode_valid),
    .flush_mode_user  (flush_mode_user),
    .look_vec         (look_vec),
    .valid_vec        (valid_vec),
    .user_vec         (user_vec),
    .dup_any          (dup_any),
    .ptr              (ptr)
);

// File: tb/test_xlat_cache.sv
module test_xlat_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [17:0] req_addr = '0;
    logic        req_user = 1'b0;
    logic        req_write = 1'b0;
    logic        refill_valid = 1'b0;
    logic        refill_user = 1'b0;
    logic [8:0]  refill_vpn = '0;
    logic [12:0] refill_ppn = '0;
    logic        refill_wr_ok = 1'b0;
    logic        flush_all = 1'b0;
    logic        flush_mode_valid = 1'b0;
    logic        flush_mode_user = 1'b0;

    logic        hit, miss, prot_fault;
    logic [21:0] phys_addr;
    logic        hit1, miss1, fault1;
    logic [21:0] phys1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int N = 16;

    always #10 clk = ~clk;

    xlat_cache #(.NUM_ENTRIES(N)) i_xlat_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_user(req_user), .req_write(req_write), .hit(hit), .miss(miss),
        .prot_fault(prot_fault), .phys_addr(phys_addr),
        .refill_valid(refill_valid), .refill_user(refill_user),
        .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
        .refill_wr_ok(refill_wr_ok), .flush_all(flush_all),
        .flush_mode_valid(flush_mode_valid), .flush_mode_user(flush_mode_user)
    );

    xlat_cache #(.NUM_ENTRIES(1)) i_xlat_cache_one (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_user(req_user), .req_write(req_write), .hit(hit1), .miss(miss1),
        .prot_fault(fault1), .phys_addr(phys1),
        .refill_valid(refill_valid), .refill_user(refill_user),
        .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
        .refill_wr_ok(refill_wr_ok), .flush_all(flush_all),
        .flush_mode_valid(flush_mode_valid), .flush_mode_user(flush_mode_user)
    );

    // outcome codes: 0 miss, 1 hit, 2 fault, 3 none
    localparam int MISS = 0, HIT = 1, FAULT = 2, NONE = 3;

    function automatic logic [12:0] ppn_for(input logic u, input logic [8:0] vpn);
        return {3'b101, u, vpn} ^ 13'h0a5;
    endfunction

    task automatic tally(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic refill(input logic u, input logic [8:0] vpn,
                          input logic [12:0] ppn, input logic wok);
        @(negedge clk);
        refill_valid = 1'b1; refill_user = u; refill_vpn = vpn;
        refill_ppn = ppn; refill_wr_ok = wok;
        @(negedge clk);
        refill_valid = 1'b0;
    endtask

    task automatic flush(input bit all, input logic u);
        @(negedge clk);
        if (all) flush_all = 1'b1;
        else begin flush_mode_valid = 1'b1; flush_mode_user = u; end
        @(negedge clk);
        flush_all = 1'b0; flush_mode_valid = 1'b0;
    endtask

    // lookup on one instance (big = 1 main, 0 single-entry)
    task automatic look(input string req, input bit big, input bit v, input logic u,
                        input logic w, input logic [8:0] vpn, input logic [8:0] off,
                        input int exp, input logic [12:0] eppn);
        int act;
        logic h, m, f;
        logic [21:0] pa;
        @(negedge clk);
        req_valid = v; req_user = u; req_write = w; req_addr = {vpn, off};
        #3;
        h  = big ? hit : hit1;
        m  = big ? miss : miss1;
        f  = big ? prot_fault : fault1;
        pa = big ? phys_addr : phys1;
        act = ({h, m, f} == 3'b100) ? HIT : ({h, m, f} == 3'b010) ? MISS :
              ({h, m, f} == 3'b001) ? FAULT : ({h, m, f} == 3'b000) ? NONE : 9;
        tally(act == exp, req, "outcome", act, exp);
        if (exp == HIT && act == HIT)
            tally(pa == {eppn, off}, req, "phys_addr", pa, {eppn, off});
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic t_reset;
        look("R10", 1, 1, 1'b1, 1'b0, 9'd5, 9'd0, MISS, '0);
        look("R10", 1, 1, 1'b0, 1'b0, 9'd511, 9'd3, MISS, '0);
        look("R3", 1, 0, 1'b1, 1'b0, 9'd5, 9'd0, NONE, '0);
    endtask

    task automatic t_basic;
        refill(1'b1, 9'd5, ppn_for(1'b1, 9'd5), 1'b1);
        look("R4", 1, 1, 1'b1, 1'b0, 9'd5, 9'h1ab, HIT, ppn_for(1'b1, 9'd5));
        look("R1", 1, 1, 1'b1, 1'b0, 9'd5, 9'h000, HIT, ppn_for(1'b1, 9'd5));
        look("R1", 1, 1, 1'b1, 1'b0, 9'd5, 9'h1ff, HIT, ppn_for(1'b1, 9'd5));
        look("R3", 1, 1, 1'b1, 1'b0, 9'd6, 9'h010, MISS, '0);
    endtask

    task automatic t_mode;
        look("R2", 1, 1, 1'b0, 1'b0, 9'd5, 9'h020, MISS, '0);
        refill(1'b0, 9'd5, ppn_for(1'b0, 9'd5), 1'b1);
        look("R2", 1, 1, 1'b0, 1'b0, 9'd5, 9'h020, HIT, ppn_for(1'b0, 9'd5));
        look("R2", 1, 1, 1'b1, 1'b0, 9'd5, 9'h020, HIT, ppn_for(1'b1, 9'd5));
    endtask

    task automatic t_prot;
        refill(1'b1, 9'd7, ppn_for(1'b1, 9'd7), 1'b0);
        look("R9", 1, 1, 1'b1, 1'b0, 9'd7, 9'h033, HIT, ppn_for(1'b1, 9'd7));
        look("R9", 1, 1, 1'b1, 1'b1, 9'd7, 9'h033, FAULT, '0);
        look("R9", 1, 1, 1'b1, 1'b1, 9'd5, 9'h033, HIT, ppn_for(1'b1, 9'd5));
    endtask

    task automatic t_mode_flush;
        flush(0, 1'b1);
        look("R7", 1, 1, 1'b1, 1'b0, 9'd5, 9'h001, MISS, '0);
        look("R7", 1, 1, 1'b1, 1'b0, 9'd7, 9'h001, MISS, '0);
        look("R7", 1, 1, 1'b0, 1'b0, 9'd5, 9'h001, HIT, ppn_for(1'b0, 9'd5));
    endtask

    task automatic t_rotation;
        flush(1, 1'b0);
        look("R6", 1, 1, 1'b0, 1'b0, 9'd5, 9'h001, MISS, '0);
        for (int k = 0; k < N; k++) refill(1'b1, 9'(100 + k), ppn_for(1'b1, 9'(100 + k)), 1'b1);
        for (int k = 0; k < N; k++)
            look("R5", 1, 1, 1'b1, 1'b0, 9'(100 + k), 9'h044, HIT, ppn_for(1'b1, 9'(100 + k)));
        refill(1'b1, 9'(100 + N), ppn_for(1'b1, 9'(100 + N)), 1'b1);
        look("R5", 1, 1, 1'b1, 1'b0, 9'd100, 9'h044, MISS, '0);
        look("R5", 1, 1, 1'b1, 1'b0, 9'd101, 9'h044, HIT, ppn_for(1'b1, 9'd101));
        look("R5", 1, 1, 1'b1, 1'b0, 9'(100 + N), 9'h044, HIT, ppn_for(1'b1, 9'(100 + N)));
    endtask

    task automatic t_duplicate;
        flush(1, 1'b0);
        refill(1'b1, 9'd200, 13'h0011, 1'b0);
        refill(1'b1, 9'd200, 13'h0022, 1'b1);
        look("R8", 1, 1, 1'b1, 1'b1, 9'd200, 9'h005, HIT, 13'h0022);
        for (int k = 1; k < N; k++) refill(1'b1, 9'(200 + k), ppn_for(1'b1, 9'(200 + k)), 1'b1);
        look("R8", 1, 1, 1'b1, 1'b0, 9'd200, 9'h005, HIT, 13'h0022);
        look("R8", 1, 1, 1'b1, 1'b0, 9'd201, 9'h005, HIT, ppn_for(1'b1, 9'd201));
        refill(1'b1, 9'(200 + N), ppn_for(1'b1, 9'(200 + N)), 1'b1);
        look("R8", 1, 1, 1'b1, 1'b0, 9'd200, 9'h005, MISS, '0);
        look("R8", 1, 1, 1'b1, 1'b0, 9'd201, 9'h005, HIT, ppn_for(1'b1, 9'd201));
    endtask

    task automatic t_collide;
        flush(1, 1'b0);
        @(negedge clk);
        refill_valid = 1'b1; refill_user = 1'b0; refill_vpn = 9'd50;
        refill_ppn = 13'h0abc; refill_wr_ok = 1'b1; flush_all = 1'b1;
        @(negedge clk);
        refill_valid = 1'b0; flush_all = 1'b0;
        look("R11", 1, 1, 1'b0, 1'b0, 9'd50, 9'h000, MISS, '0);
        @(negedge clk);
        refill_valid = 1'b1; refill_user = 1'b0; refill_vpn = 9'd51;
        flush_mode_valid = 1'b1; flush_mode_user = 1'b1;
        @(negedge clk);
        refill_valid = 1'b0; flush_mode_valid = 1'b0;
        look("R11", 1, 1, 1'b0, 1'b0, 9'd51, 9'h000, MISS, '0);
    endtask

    task automatic t_single;
        flush(1, 1'b0);
        refill(1'b0, 9'd300 % 512, ppn_for(1'b0, 9'd44), 1'b1);
        look("R12", 0, 1, 1'b0, 1'b0, 9'd300 % 512, 9'h0f0, HIT, ppn_for(1'b0, 9'd44));
        refill(1'b0, 9'd301 % 512, ppn_for(1'b0, 9'd45), 1'b1);
        look("R12", 0, 1, 1'b0, 1'b0, 9'd300 % 512, 9'h0f0, MISS, '0);
        look("R12", 0, 1, 1'b0, 1'b0, 9'd301 % 512, 9'h0f0, HIT, ppn_for(1'b0, 9'd45));
        look("R12", 1, 1, 1'b0, 1'b0, 9'd300 % 512, 9'h0f0, HIT, ppn_for(1'b0, 9'd44));
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_mode();
        t_prot();
        t_mode_flush();
        t_rotation();
        t_duplicate();
        t_collide();
        t_single();
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog run did not complete");
        finish_up();
    end

endmodule